// File: doc/BRIEF.md
# Reservation Pool Wakeup and Select

This block is one pool of reservation entries in an out-of-order core. Dispatch writes an instruction into a free entry together with a sequence number, two producer tags and a ready flag for each source. Every cycle each waiting entry compares its unready tags against the tag on the result broadcast bus and marks a source ready when the tags match.

An entry whose sources are both ready competes for the functional units of its class. Grants go out oldest first, and several entries can be granted in one cycle when several units are free. A granted entry keeps its slot while the instruction executes. The slot is returned when the execution side reports that the instruction is leaving for the broadcast stage, and dispatch can reuse it in that same cycle. Operand values and execution timing live outside this block.

Top module: `rs_pool_sched`

## Requirements
- R1: After reset every entry is free: `alloc_ready_o` is 1, `free_count_o` equals NUM_ENTRIES and no grant is raised.
- R2: When `alloc_valid_i` and `alloc_ready_o` are both high, the request is written into the entry shown on `alloc_idx_o`. That entry is the lowest-numbered free entry or, if none is free, the entry being released in this cycle.
- R3: An entry written with both sources ready is not granted in its allocation cycle. It can be granted from the next cycle on.
- R4: A broadcast whose tag matches an unready source marks that source ready, and this includes a broadcast in the allocation cycle itself. The entry can be granted at the earliest in the cycle after the broadcast.
- R5: An entry with any source not ready is never granted.
- R6: Among ready entries, age is decided by the sequence number using modular (wraparound) comparison: a is older than b when the most significant bit of a minus b is 1. `grant_idx_o` and `grant_seq_o` for unit j (field j, IDX_W and SEQ_W bits wide) name the granted entry and its sequence number.
- R7: Grants are given only to free units (`fu_free_i` bit j). The k-th oldest ready entry goes to the k-th lowest-numbered free unit, and no entry is granted twice in one cycle.
- R8: A granted entry stays occupied and is not counted in `free_count_o` until it is released. It is never granted again while it executes.
- R9: A release (`done_valid_i` with `done_idx_i`) of an executing entry makes `alloc_ready_o` high and adds that entry to `free_count_o` in the same cycle. The entry is free, or reallocated, from the next cycle.
- R10: An allocation request while `alloc_ready_o` is low has no effect. A release that names an entry that is not executing, or an index of NUM_ENTRIES or above, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Dispatch request |
| alloc_seq_i | input | SEQ_W | Sequence number of the request |
| alloc_src0_tag_i | input | TAG_W | Producer tag of source 0 |
| alloc_src0_rdy_i | input | 1 | Source 0 already available |
| alloc_src1_tag_i | input | TAG_W | Producer tag of source 1 |
| alloc_src1_rdy_i | input | 1 | Source 1 already available |
| alloc_ready_o | output | 1 | An entry can accept the request this cycle |
| alloc_idx_o | output | IDX_W | Entry that receives the request |
| free_count_o | output | CNT_W | Free entries, counting one released this cycle |
| cdb_valid_i | input | 1 | Result broadcast valid |
| cdb_tag_i | input | TAG_W | Result broadcast tag |
| fu_free_i | input | NUM_FU | Per-unit free flags |
| done_valid_i | input | 1 | Execution finished for an entry |
| done_idx_i | input | IDX_W | Entry whose execution finished |
| grant_valid_o | output | NUM_FU | Grant per unit |
| grant_idx_o | output | NUM_FU*IDX_W | Granted entry per unit |
| grant_seq_o | output | NUM_FU*SEQ_W | Sequence number of the granted entry per unit |

## Verification
The bench goes after the timing edges of wakeup. One case is a broadcast that arrives in the allocation cycle, which a design that captured only the stored tag would lose, so the entry would hang. Another is a broadcast to an entry that is already waiting, which a bypassing design would grant one cycle early. The bench also fills the pool and releases an entry in the same cycle as a new request, so a design that looked only at registered free flags would stall dispatch for one cycle. Random traffic lets the sequence numbers wrap many times and uses sparse free-unit masks. A plain magnitude compare would then grant a younger entry, and a naive unit mapping would place a grant on a busy unit or give one entry two units.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_WAIT = 2'd1,
    RS_EXEC = 2'd2
  } rs_state_e;
endpackage

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int SEQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_en_i,
  input  logic [SEQ_W-1:0] alloc_seq_i,
  input  logic [TAG_W-1:0] alloc_tag0_i,
  input  logic             alloc_rdy0_i,
  input  logic [TAG_W-1:0] alloc_tag1_i,
  input  logic             alloc_rdy1_i,
  input  logic             cdb_valid_i,
  input  logic [TAG_W-1:0] cdb_tag_i,
  input  logic             issue_en_i,
  input  logic             release_en_i,
  output logic             idle_o,
  output logic             exec_o,
  output logic             elig_o,
  output logic [SEQ_W-1:0] seq_o
);
  rs_state_e        state_q;
  logic             rdy0_q, rdy1_q;
  logic [TAG_W-1:0] tag0_q, tag1_q;
  logic [SEQ_W-1:0] seq_q;

  logic new_hit0, new_hit1, hit0, hit1;
  assign new_hit0 = cdb_valid_i && (cdb_tag_i == alloc_tag0_i);
  assign new_hit1 = cdb_valid_i && (cdb_tag_i == alloc_tag1_i);
  assign hit0     = cdb_valid_i && (cdb_tag_i == tag0_q);
  assign hit1     = cdb_valid_i && (cdb_tag_i == tag1_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_IDLE;
      rdy0_q  <= 1'b0;
      rdy1_q  <= 1'b0;
      tag0_q  <= '0;
      tag1_q  <= '0;
      seq_q   <= '0;
    end else if (alloc_en_i) begin
      state_q <= RS_WAIT;
      seq_q   <= alloc_seq_i;
      tag0_q  <= alloc_tag0_i;
      tag1_q  <= alloc_tag1_i;
      rdy0_q  <= alloc_rdy0_i | new_hit0;
      rdy1_q  <= alloc_rdy1_i | new_hit1;
    end else begin
      unique case (state_q)
        RS_WAIT: begin
          if (issue_en_i) state_q <= RS_EXEC;
          if (hit0) rdy0_q <= 1'b1;
          if (hit1) rdy1_q <= 1'b1;
        end
        RS_EXEC: begin
          if (release_en_i) state_q <= RS_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign idle_o = (state_q == RS_IDLE);
  assign exec_o = (state_q == RS_EXEC);
  assign elig_o = (state_q == RS_WAIT) && rdy0_q && rdy1_q;
  assign seq_o  = seq_q;
endmodule

// File: rtl/rs_age_rank.sv
module rs_age_rank #(
  parameter int NUM_ENTRIES = 5,
  parameter int SEQ_W       = 8,
  parameter int CNT_W       = 3
) (
  input  logic [NUM_ENTRIES-1:0]       elig_i,
  input  logic [NUM_ENTRIES*SEQ_W-1:0] seq_i,
  output logic [NUM_ENTRIES*CNT_W-1:0] rank_o
);
  function automatic logic is_older(logic [SEQ_W-1:0] a, logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_rank
    logic [CNT_W-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int j = 0; j < NUM_ENTRIES; j++) begin
        if (j != i && elig_i[j] &&
            is_older(seq_i[j*SEQ_W +: SEQ_W], seq_i[i*SEQ_W +: SEQ_W]))
          cnt = cnt + 1'b1;
      end
    end
    assign rank_o[i*CNT_W +: CNT_W] = cnt;
  end
endmodule

// File: rtl/rs_fu_assign.sv
module rs_fu_assign #(
  parameter int NUM_ENTRIES = 5,
  parameter int NUM_FU      = 3,
  parameter int IDX_W       = 3,
  parameter int CNT_W       = 3
) (
  input  logic [NUM_ENTRIES-1:0]       elig_i,
  input  logic [NUM_ENTRIES*CNT_W-1:0] rank_i,
  input  logic [NUM_FU-1:0]            fu_free_i,
  output logic [NUM_FU-1:0]            grant_valid_o,
  output logic [NUM_FU*IDX_W-1:0]      grant_idx_o,
  output logic [NUM_ENTRIES-1:0]       issue_en_o
);
  // k-th free unit (by index) takes the entry of rank k
  always_comb begin
    int pos;
    pos           = 0;
    grant_valid_o = '0;
    grant_idx_o   = '0;
    issue_en_o    = '0;
    for (int j = 0; j < NUM_FU; j++) begin
      if (fu_free_i[j]) begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
          if (elig_i[i] && int'(rank_i[i*CNT_W +: CNT_W]) == pos) begin
            grant_valid_o[j]                 = 1'b1;
            grant_idx_o[j*IDX_W +: IDX_W]    = IDX_W'(i);
            issue_en_o[i]                    = 1'b1;
          end
        end
        pos = pos + 1;
      end
    end
  end
endmodule

// File: rtl/rs_alloc_pick.sv
module rs_alloc_pick #(
  parameter int NUM_ENTRIES = 5,
  parameter int IDX_W       = 3,
  parameter int CNT_W       = 3
) (
  input  logic [NUM_ENTRIES-1:0] idle_i,
  input  logic                   rel_valid_i,
  input  logic [IDX_W-1:0]       rel_idx_i,
  output logic                   ready_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [CNT_W-1:0]       count_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    idx_o = rel_idx_i;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (idle_i[i]) begin
        found = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
    ready_o = found | rel_valid_i;
    count_o = CNT_W'($countones(idle_i)) + CNT_W'(rel_valid_i);
  end
endmodule

// File: rtl/rs_pool_sched.sv
module rs_pool_sched #(
  parameter int NUM_ENTRIES = 5,
  parameter int NUM_FU      = 3,
  parameter int TAG_W       = 4,
  parameter int SEQ_W       = 8,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    alloc_valid_i,
  input  logic [SEQ_W-1:0]        alloc_seq_i,
  input  logic [TAG_W-1:0]        alloc_src0_tag_i,
  input  logic                    alloc_src0_rdy_i,
  input  logic [TAG_W-1:0]        alloc_src1_tag_i,
  input  logic                    alloc_src1_rdy_i,
  output logic                    alloc_ready_o,
  output logic [IDX_W-1:0]        alloc_idx_o,
  output logic [CNT_W-1:0]        free_count_o,
  input  logic                    cdb_valid_i,
  input  logic [TAG_W-1:0]        cdb_tag_i,
  input  logic [NUM_FU-1:0]       fu_free_i,
  input  logic                    done_valid_i,
  input  logic [IDX_W-1:0]        done_idx_i,
  output logic [NUM_FU-1:0]       grant_valid_o,
  output logic [NUM_FU*IDX_W-1:0] grant_idx_o,
  output logic [NUM_FU*SEQ_W-1:0] grant_seq_o
);
  logic [NUM_ENTRIES-1:0]       idle_v, exec_v, elig_v, issue_en, rel_en, alloc_en;
  logic [NUM_ENTRIES*SEQ_W-1:0] seq_flat;
  logic [NUM_ENTRIES*CNT_W-1:0] rank_flat;
  logic                         rel_hit;

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      rel_en[i]   = done_valid_i && (done_idx_i == IDX_W'(i)) && exec_v[i];
      alloc_en[i] = alloc_valid_i && alloc_ready_o && (alloc_idx_o == IDX_W'(i));
    end
  end
  assign rel_hit = |rel_en;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    rs_entry #(
      .TAG_W(TAG_W),
      .SEQ_W(SEQ_W)
    ) i_entry (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_en_i   (alloc_en[i]),
      .alloc_seq_i  (alloc_seq_i),
      .alloc_tag0_i (alloc_src0_tag_i),
      .alloc_rdy0_i (alloc_src0_rdy_i),
      .alloc_tag1_i (alloc_src1_tag_i),
      .alloc_rdy1_i (alloc_src1_rdy_i),
      .cdb_valid_i  (cdb_valid_i),
      .cdb_tag_i    (cdb_tag_i),
      .issue_en_i   (issue_en[i]),
      .release_en_i (rel_en[i]),
      .idle_o       (idle_v[i]),
      .exec_o       (exec_v[i]),
      .elig_o       (elig_v[i]),
      .seq_o        (seq_flat[i*SEQ_W +: SEQ_W])
    );
  end

  rs_alloc_pick #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W)
  ) i_alloc_pick (
    .idle_i      (idle_v),
    .rel_valid_i (rel_hit),
    .rel_idx_i   (done_idx_i),
    .ready_o     (alloc_ready_o),
    .idx_o       (alloc_idx_o),
    .count_o     (free_count_o)
  );

  rs_age_rank #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .SEQ_W      (SEQ_W),
    .CNT_W      (CNT_W)
  ) i_age_rank (
    .elig_i (elig_v),
    .seq_i  (seq_flat),
    .rank_o (rank_flat)
  );

  rs_fu_assign #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .NUM_FU     (NUM_FU),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W)
  ) i_fu_assign (
    .elig_i        (elig_v),
    .rank_i        (rank_flat),
    .fu_free_i     (fu_free_i),
    .grant_valid_o (grant_valid_o),
    .grant_idx_o   (grant_idx_o),
    .issue_en_o    (issue_en)
  );

  always_comb begin
    grant_seq_o = '0;
    for (int j = 0; j < NUM_FU; j++) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (grant_valid_o[j] && grant_idx_o[j*IDX_W +: IDX_W] == IDX_W'(i))
          grant_seq_o[j*SEQ_W +: SEQ_W] = seq_flat[i*SEQ_W +: SEQ_W];
      end
    end
  end
endmodule

// File: rtl/rs_pool_sched_chk.sv
module rs_pool_sched_chk #(
  parameter int NUM_ENTRIES = 5,
  parameter int NUM_FU      = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   alloc_valid_i,
  input logic                   alloc_ready_o,
  input logic [NUM_FU-1:0]      fu_free_i,
  input logic [NUM_FU-1:0]      grant_valid_o,
  input logic [NUM_ENTRIES-1:0] issue_en,
  input logic [NUM_ENTRIES-1:0] elig_v,
  input logic [NUM_ENTRIES-1:0] alloc_en,
  input logic [NUM_ENTRIES-1:0] rel_en
);
  assert_grant_free_unit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o & ~fu_free_i) == '0);

  assert_grant_unique_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(grant_valid_o) == $countones(issue_en));

  assert_no_grant_on_alloc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_ready_o) |-> (issue_en & alloc_en) == '0);

  assert_grant_needs_ready_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_en & ~elig_v) == '0);

  assert_granted_stays_out_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|issue_en) |=> (elig_v & $past(issue_en)) == '0);

  assert_release_opens_slot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rel_en) |-> alloc_ready_o);
endmodule

bind rs_pool_sched rs_pool_sched_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .NUM_FU     (NUM_FU)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .alloc_valid_i (alloc_valid_i),
  .alloc_ready_o (alloc_ready_o),
  .fu_free_i     (fu_free_i),
  .grant_valid_o (grant_valid_o),
  .issue_en      (issue_en),
  .elig_v        (elig_v),
  .alloc_en      (alloc_en),
  .rel_en        (rel_en)
);

// File: tb/test_rs_pool_sched.sv
`timescale 1ns/1ps
module test_rs_pool_sched;
  localparam int N = 5, F = 3, TW = 4, SW = 8, IW = 3, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          alloc_v, ar0, ar1, cdb_v, done_v;
  logic [SW-1:0] alloc_seq;
  logic [TW-1:0] at0, at1, cdb_t;
  logic [F-1:0]  fu_free;
  logic [IW-1:0] done_idx;
  logic          alloc_ready;
  logic [IW-1:0] alloc_idx;
  logic [CW-1:0] free_count;
  logic [F-1:0]  gv;
  logic [F*IW-1:0] gi;
  logic [F*SW-1:0] gs;

  rs_pool_sched i_rs_pool_sched (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_v), .alloc_seq_i(alloc_seq),
    .alloc_src0_tag_i(at0), .alloc_src0_rdy_i(ar0),
    .alloc_src1_tag_i(at1), .alloc_src1_rdy_i(ar1),
    .alloc_ready_o(alloc_ready), .alloc_idx_o(alloc_idx), .free_count_o(free_count),
    .cdb_valid_i(cdb_v), .cdb_tag_i(cdb_t), .fu_free_i(fu_free),
    .done_valid_i(done_v), .done_idx_i(done_idx),
    .grant_valid_o(gv), .grant_idx_o(gi), .grant_seq_o(gs)
  );

  int n_cmp = 0, n_bad = 0;
  bit done_flag = 0;
  logic [SW-1:0] next_seq = '0;

  int m_st[N];
  bit m_r0[N], m_r1[N];
  logic [TW-1:0] m_t0[N], m_t1[N];
  logic [SW-1:0] m_sq[N];

  bit e_ready, e_rel;
  int e_idx, e_cnt;
  logic [F-1:0] e_gv;
  int e_gi[F];
  bit e_iss[N];

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit older(logic [SW-1:0] a, logic [SW-1:0] b);
    logic [SW-1:0] d;
    d = a - b;
    return d[SW-1];
  endfunction

  task automatic predict();
    int rank[N];
    bit el[N];
    int pos;
    e_rel = done_v && int'(done_idx) < N && m_st[int'(done_idx)] == 2;
    e_cnt = e_rel ? 1 : 0;
    e_idx = -1;
    for (int i = 0; i < N; i++)
      if (m_st[i] == 0) begin
        e_cnt++;
        if (e_idx < 0) e_idx = i;
      end
    if (e_idx < 0 && e_rel) e_idx = int'(done_idx);
    e_ready = e_cnt > 0;
    for (int i = 0; i < N; i++) begin
      el[i] = m_st[i] == 1 && m_r0[i] && m_r1[i];
      e_iss[i] = 0;
    end
    for (int i = 0; i < N; i++) begin
      rank[i] = 0;
      for (int j = 0; j < N; j++)
        if (j != i && el[j] && older(m_sq[j], m_sq[i])) rank[i]++;
    end
    e_gv = '0;
    pos = 0;
    for (int j = 0; j < F; j++) begin
      e_gi[j] = 0;
      if (fu_free[j]) begin
        for (int i = 0; i < N; i++)
          if (el[i] && rank[i] == pos) begin
            e_gv[j] = 1'b1;
            e_gi[j] = i;
            e_iss[i] = 1;
          end
        pos++;
      end
    end
  endtask

  task automatic compare();
    chk(e_rel ? "R9 alloc_ready" : "R2 alloc_ready", alloc_ready, e_ready);
    if (e_ready) chk("R2 alloc_idx", alloc_idx, e_idx);
    chk("R8 free_count", free_count, e_cnt);
    chk("R7 grant_valid", gv, e_gv);
    for (int j = 0; j < F; j++)
      if (e_gv[j]) begin
        chk("R6 grant_idx", gi[j*IW +: IW], e_gi[j]);
        chk("R6 grant_seq", gs[j*SW +: SW], m_sq[e_gi[j]]);
      end
  endtask

  task automatic update();
    bit fire;
    fire = alloc_v && e_ready;
    for (int i = 0; i < N; i++) begin
      if (fire && i == e_idx) begin
        m_st[i] = 1;
        m_sq[i] = alloc_seq;
        m_t0[i] = at0;
        m_t1[i] = at1;
        m_r0[i] = ar0 || (cdb_v && cdb_t == at0);
        m_r1[i] = ar1 || (cdb_v && cdb_t == at1);
      end else if (m_st[i] == 1) begin
        if (e_iss[i]) m_st[i] = 2;
        if (cdb_v && cdb_t == m_t0[i]) m_r0[i] = 1;
        if (cdb_v && cdb_t == m_t1[i]) m_r1[i] = 1;
      end else if (m_st[i] == 2 && e_rel && i == int'(done_idx)) begin
        m_st[i] = 0;
      end
    end
    if (fire) next_seq = next_seq + 1'b1;
  endtask

  task automatic step();
    #1;
    predict();
    compare();
    update();
    @(negedge clk);
  endtask

  task automatic idle_in();
    alloc_v = 0; alloc_seq = next_seq; ar0 = 0; ar1 = 0; at0 = '0; at1 = '0;
    cdb_v = 0; cdb_t = '0; fu_free = '0; done_v = 0; done_idx = '0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < N; i++) begin
      m_st[i] = 0; m_r0[i] = 0; m_r1[i] = 0; m_t0[i] = '0; m_t1[i] = '0; m_sq[i] = '0;
    end
    idle_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset alloc_ready", alloc_ready, 1);
    chk("R1 reset free_count", free_count, N);
    chk("R1 reset grants", gv, 0);
    step();

    // R3: ready at allocation, not granted that cycle
    idle_in(); alloc_v = 1; ar0 = 1; ar1 = 1; fu_free = 3'b111;
    #1 chk("R3 no grant in alloc cycle", gv, 0);
    step();
    idle_in(); fu_free = 3'b111;
    #1 chk("R3 grant next cycle", gv, 3'b001);
    chk("R3 grant entry", gi[0 +: IW], 0);
    step();

    // R4: broadcast in the allocation cycle is captured
    idle_in(); alloc_v = 1; at0 = 4'd5; ar1 = 1; cdb_v = 1; cdb_t = 4'd5;
    step();
    idle_in(); fu_free = 3'b001;
    #1 chk("R4 wake at alloc", gv, 3'b001);
    chk("R4 wake at alloc entry", gi[0 +: IW], 1);
    step();

    // R5 then R4: waiting source, later broadcast, no bypass
    idle_in(); alloc_v = 1; at0 = 4'd7; ar1 = 1;
    step();
    idle_in(); fu_free = 3'b111;
    #1 chk("R5 unready held", gv, 0);
    step();
    idle_in(); fu_free = 3'b111; cdb_v = 1; cdb_t = 4'd7;
    #1 chk("R4 no grant in broadcast cycle", gv, 0);
    step();
    idle_in(); fu_free = 3'b111;
    #1 chk("R4 grant after wake", gv, 3'b001);
    chk("R4 grant after wake entry", gi[0 +: IW], 2);
    step();

    // fill pool with two waiters on tag 9
    idle_in(); alloc_v = 1; at0 = 4'd9; at1 = 4'd9;
    step();
    idle_in(); alloc_v = 1; at0 = 4'd9; at1 = 4'd9;
    step();

    // R10: full pool ignores request; bad release ignored
    idle_in(); alloc_v = 1; ar0 = 1; ar1 = 1;
    #1 chk("R10 full alloc_ready", alloc_ready, 0);
    chk("R10 full free_count", free_count, 0);
    step();
    idle_in(); done_v = 1; done_idx = 3'd3;
    #1 chk("R10 release of waiting entry", free_count, 0);
    step();
    idle_in(); done_v = 1; done_idx = 3'd6;
    #1 chk("R10 release out of range", alloc_ready, 0);
    step();

    // R9: release and reallocate in the same cycle
    idle_in(); done_v = 1; done_idx = 3'd1; alloc_v = 1; ar0 = 1; ar1 = 1;
    #1 chk("R9 ready on release", alloc_ready, 1);
    chk("R9 idx on release", alloc_idx, 1);
    chk("R9 count on release", free_count, 1);
    step();

    // R7: single free unit at index 2
    idle_in(); fu_free = 3'b100;
    #1 chk("R7 grant on lone free unit", gv, 3'b100);
    chk("R7 lone unit entry", gi[2*IW +: IW], 1);
    step();

    // R6: wake two, older to lower unit
    idle_in(); cdb_v = 1; cdb_t = 4'd9;
    step();
    idle_in(); fu_free = 3'b011;
    #1 chk("R6 oldest to unit 0", gi[0 +: IW], 3);
    chk("R6 next to unit 1", gi[IW +: IW], 4);
    step();

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      int span;
      idle_in();
      alloc_v = ($urandom % 3) != 0;
      ar0 = $urandom % 2; ar1 = $urandom % 2;
      at0 = TW'($urandom); at1 = TW'($urandom);
      cdb_v = $urandom % 2; cdb_t = TW'($urandom);
      fu_free = F'($urandom);
      done_v = ($urandom % 3) != 0; done_idx = IW'($urandom);
      span = 0;
      for (int i = 0; i < N; i++)
        if (m_st[i] != 0 && int'(SW'(next_seq - m_sq[i])) > span)
          span = int'(SW'(next_seq - m_sq[i]));
      if (span >= 100) alloc_v = 0;
      step();
    end

    done_flag = 1;
    summary();
    $finish;
  end
endmodule